// File: doc/BRIEF.md
# Multi-Mode ADC Channel Sequencer

This block paces conversion-start strobes toward an eight-input ADC front end. For every strobe it chooses which input to convert and at what gain. A go bit and a rate divisor control it. The divisor counts cycles of the block's own clock, which acts as the base clock. A nonzero divisor gives a periodic start stream. A zero divisor gives one conversion, or one pass over the channel list, each time go is raised.

A two-bit mode field selects one of four ways to pick the channel and gain:
- **Single-input:** the same input is converted every time.
- **Basic scan:** the scan walks from input 0 up to a programmable last input, all at one shared gain.
- **Advanced scan:** the same walk, but each input takes its own gain from a per-input table.
- **Live update:** adopts a new last input and shared gain while a scan is already running, without restarting the scan.

Every result that the converter hands back is tagged with the input it came from and with a converter-select bit. A downstream consumer can then form a four-bit logical channel number from these two tags.

The sequencer never starts a conversion while the previous one is still outstanding. When a pacing tick lands on a busy converter, that tick is dropped and flagged as a missed start.

Top module: `adcseq_top`

## Requirements
- R1: With go high and rateDiv = N > 0, and the converter finishing well within N cycles, consecutive convStart pulses are exactly N clock cycles apart.
- R2: With rateDiv = 0, raising go yields exactly one convStart in single-input mode, or exactly lastChan+1 convStarts (inputs 0..lastChan) in a scan mode. No further starts follow while go stays high. Lowering and raising go again repeats this.
- R3: Mode 2'b00 (single-input): every convStart carries convChan = lastChan and convGain = globalGain.
- R4: Mode 2'b11 (basic scan): successive starts carry convChan 0, 1, …, lastChan, then wrap to 0, all with convGain = globalGain.
- R5: Mode 2'b10 (advanced scan): channels step as in R4, and input c uses convGain = gainTable[3c+2:3c]; globalGain has no effect on any start.
- R6: Mode 2'b01 written while running: the new lastChan and globalGain take effect from the next start, and the channel pointer continues from where it was instead of returning to 0.
- R7: In modes 00, 10 and 11, lastChan, globalGain and the mode are captured when go rises; later changes to them have no effect until go is lowered and raised again.
- R8: While go is low no convStart is issued; this holds in the cycle right after go is seen low. After go has been low, the next scan begins at input 0. After reset convStart, resValid and missedStart are 0.
- R9: No convStart is issued between a start and the converter's adcDone, nor while adcBusy is high. A pacing tick that falls in that time produces a one-cycle missedStart pulse instead of a start.
- R10: One cycle after adcDone, resValid pulses for one cycle with resData = adcData, resChan = the input of that conversion, resSel = adcSel and resLogical = {resSel, resChan}, that is resChan + 8 when resSel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; also the pacing time base |
| rstN | input | 1 | Active-low synchronous reset |
| goEn | input | 1 | Run enable |
| seqMode | input | 2 | Mode: 00 single-input, 11 basic scan, 10 advanced scan, 01 live update |
| lastChan | input | 3 | Single-input channel, or last input of a scan |
| globalGain | input | 3 | Shared gain code |
| gainTable | input | 24 | Per-input gain codes, input c at bits 3c+2:3c |
| rateDiv | input | 16 | Pacing divisor in base-clock cycles; 0 means single shot |
| adcSel | input | 1 | Converter-select tag copied into results |
| adcBusy | input | 1 | Converter busy indication |
| adcDone | input | 1 | One-cycle pulse: adcData holds a finished result |
| adcData | input | 16 | Converter result word |
| convStart | output | 1 | One-cycle conversion start strobe |
| convChan | output | 3 | Input selected for the current conversion |
| convGain | output | 3 | Gain code for the current conversion |
| missedStart | output | 1 | One-cycle pulse for a pacing tick dropped on a busy converter |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | 16 | Captured result word |
| resChan | output | 3 | Input that produced the result |
| resSel | output | 1 | Converter-select tag of the result |
| resLogical | output | 4 | Logical channel, {resSel, resChan} |

## Verification
The embedded properties assume that the converter raises adcDone exactly once for each start, and only after that start. They also assume that adcBusy never stays high without a start being outstanding. The model in the bench guarantees both: it answers every convStart with a busy window of fixed length that ends in a single adcDone. It also carries the channel and gain of the conversion inside the returned word, so results can be matched to their starts.

All inputs change half a cycle away from the sampling edge. Mode and setting changes are made in the gap between two starts. Go is only raised again once any outstanding conversion has drained.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    SEQ_SINGLE = 2'b00,
    SEQ_UPDATE = 2'b01,
    SEQ_ADV    = 2'b10,
    SEQ_BASIC  = 2'b11
  } seqMode_e;

  // Strobes from the control engine to the datapath
  typedef struct packed {
    logic loadCfg;   // go just rose: capture settings
    logic updCfg;    // live update of last channel / gain
    logic issue;     // a conversion starts at this edge
    logic clearPtr;  // go is low: return pointer to input 0
    logic capture;   // converter result is ready
  } seqStrobe_t;

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goEn,
  input  logic [1:0]       seqMode,
  input  logic [DIV_W-1:0] rateDiv,
  input  logic             adcBusy,
  input  logic             adcDone,
  input  logic             lastOfScan,
  output seqStrobe_t       strobe,
  output logic             convStart,
  output logic             missedStart
);

  logic             goQ;
  logic             waiting;
  logic             shotActive;
  logic [DIV_W-1:0] paceCnt;

  logic running, goRise, paced, paceTick, busyNow, shotTick, issue, missHit;

  always_comb begin
    running  = goEn & goQ;
    goRise   = goEn & ~goQ;
    paced    = running & (rateDiv != '0) & ~shotActive;
    paceTick = paced & (paceCnt == '0);
    busyNow  = waiting | adcBusy;
    shotTick = running & shotActive & ~busyNow;
    issue    = (paceTick & ~busyNow) | shotTick;
    missHit  = paceTick & busyNow;
  end

  always_comb begin
    strobe.loadCfg  = goRise;
    strobe.updCfg   = running & (seqMode == SEQ_UPDATE);
    strobe.issue    = issue;
    strobe.clearPtr = ~goEn;
    strobe.capture  = adcDone;
  end

  // Pacing divider: tick when count is zero, period rateDiv cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      paceCnt <= '0;
    end else if (!paced) begin
      paceCnt <= '0;
    end else if (paceCnt >= rateDiv - DIV_W'(1)) begin
      paceCnt <= '0;
    end else begin
      paceCnt <= paceCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goQ         <= 1'b0;
      waiting     <= 1'b0;
      shotActive  <= 1'b0;
      convStart   <= 1'b0;
      missedStart <= 1'b0;
    end else begin
      goQ         <= goEn;
      convStart   <= issue;
      missedStart <= missHit;
      if (issue) begin
        waiting <= 1'b1;
      end else if (adcDone) begin
        waiting <= 1'b0;
      end
      if (goRise) begin
        shotActive <= (rateDiv == '0);
      end else if (!goEn) begin
        shotActive <= 1'b0;
      end else if (shotTick && lastOfScan) begin
        shotActive <= 1'b0;
      end
    end
  end

  AST_STOP_ON_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !goEn |=> !convStart);  // R8

  AST_START_IS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);  // R9

  AST_MISS_NOT_START: assert property (@(posedge clk) disable iff (!rstN)
    missedStart |-> !convStart);  // R9

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    adcBusy |=> !convStart);  // R9

endmodule

// File: rtl/adcseq_dpath.sv
module adcseq_dpath
  import adcseq_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int GAIN_W   = 3,
  parameter int DATA_W   = 16,
  localparam int CH_W    = $clog2(NUM_CHAN)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobe,
  input  logic [1:0]                 seqMode,
  input  logic [CH_W-1:0]            lastChan,
  input  logic [GAIN_W-1:0]          globalGain,
  input  logic [NUM_CHAN*GAIN_W-1:0] gainTable,
  input  logic                       adcSel,
  input  logic [DATA_W-1:0]          adcData,
  output logic [CH_W-1:0]            convChan,
  output logic [GAIN_W-1:0]          convGain,
  output logic                       lastOfScan,
  output logic                       resValid,
  output logic [DATA_W-1:0]          resData,
  output logic [CH_W-1:0]            resChan,
  output logic                       resSel,
  output logic [CH_W:0]              resLogical
);

  seqMode_e          cfgMode;
  logic [CH_W-1:0]   cfgLast;
  logic [GAIN_W-1:0] cfgGain;
  logic [CH_W-1:0]   ptr;

  logic [GAIN_W-1:0] chanGain [NUM_CHAN];

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_gainSlice
    assign chanGain[g] = gainTable[g*GAIN_W +: GAIN_W];
  end

  logic              seqActive;
  logic [CH_W-1:0]   curChan;
  logic [GAIN_W-1:0] curGain;

  always_comb begin
    seqActive  = (cfgMode != SEQ_SINGLE);
    curChan    = seqActive ? ptr : cfgLast;
    curGain    = (cfgMode == SEQ_ADV) ? chanGain[ptr] : cfgGain;
    lastOfScan = !seqActive || (ptr >= cfgLast);
    resLogical = {resSel, resChan};
  end

  // Captured settings
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode <= SEQ_SINGLE;
      cfgLast <= '0;
      cfgGain <= '0;
    end else if (strobe.loadCfg) begin
      cfgMode <= (seqMode == SEQ_UPDATE) ? SEQ_BASIC : seqMode_e'(seqMode);
      cfgLast <= lastChan;
      cfgGain <= globalGain;
    end else if (strobe.updCfg) begin
      cfgLast <= lastChan;
      cfgGain <= globalGain;
      if (cfgMode == SEQ_SINGLE) begin
        cfgMode <= SEQ_BASIC;
      end
    end
  end

  // Scan pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.clearPtr) begin
      ptr <= '0;
    end else if (strobe.issue && seqActive) begin
      ptr <= (ptr >= cfgLast) ? '0 : ptr + CH_W'(1);
    end
  end

  // Conversion selection, held until the next start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      convChan <= '0;
      convGain <= '0;
    end else if (strobe.issue) begin
      convChan <= curChan;
      convGain <= curGain;
    end
  end

  // Result tagging
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
      resChan  <= '0;
      resSel   <= 1'b0;
    end else begin
      resValid <= strobe.capture;
      if (strobe.capture) begin
        resData <= adcData;
        resChan <= convChan;
        resSel  <= adcSel;
      end
    end
  end

  AST_SINGLE_CHAN: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.issue) && ($past(cfgMode) == SEQ_SINGLE) |-> convChan == $past(cfgLast));  // R3

  AST_SCAN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue && seqActive && (ptr >= cfgLast) |=> ptr == '0);  // R4

  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearPtr |=> ptr == '0);  // R8

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> resValid);  // R10

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !resValid);  // R10

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int GAIN_W   = 3,
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 16,
  localparam int CH_W    = $clog2(NUM_CHAN)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       goEn,
  input  logic [1:0]                 seqMode,
  input  logic [CH_W-1:0]            lastChan,
  input  logic [GAIN_W-1:0]          globalGain,
  input  logic [NUM_CHAN*GAIN_W-1:0] gainTable,
  input  logic [DIV_W-1:0]           rateDiv,
  input  logic                       adcSel,
  input  logic                       adcBusy,
  input  logic                       adcDone,
  input  logic [DATA_W-1:0]          adcData,
  output logic                       convStart,
  output logic [CH_W-1:0]            convChan,
  output logic [GAIN_W-1:0]          convGain,
  output logic                       missedStart,
  output logic                       resValid,
  output logic [DATA_W-1:0]          resData,
  output logic [CH_W-1:0]            resChan,
  output logic                       resSel,
  output logic [CH_W:0]              resLogical
);

  seqStrobe_t strobe;
  logic       lastOfScan;

  adcseq_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .goEn        (goEn),
    .seqMode     (seqMode),
    .rateDiv     (rateDiv),
    .adcBusy     (adcBusy),
    .adcDone     (adcDone),
    .lastOfScan  (lastOfScan),
    .strobe      (strobe),
    .convStart   (convStart),
    .missedStart (missedStart)
  );

  adcseq_dpath #(
    .NUM_CHAN (NUM_CHAN),
    .GAIN_W   (GAIN_W),
    .DATA_W   (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .seqMode    (seqMode),
    .lastChan   (lastChan),
    .globalGain (globalGain),
    .gainTable  (gainTable),
    .adcSel     (adcSel),
    .adcData    (adcData),
    .convChan   (convChan),
    .convGain   (convGain),
    .lastOfScan (lastOfScan),
    .resValid   (resValid),
    .resData    (resData),
    .resChan    (resChan),
    .resSel     (resSel),
    .resLogical (resLogical)
  );

endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        goEn;
  logic [1:0]  seqMode;
  logic [2:0]  lastChan;
  logic [2:0]  globalGain;
  logic [23:0] gainTable;
  logic [15:0] rateDiv;
  logic        adcSel;
  logic        adcBusy;
  logic        adcDone;
  logic [15:0] adcData;
  logic        convStart;
  logic [2:0]  convChan;
  logic [2:0]  convGain;
  logic        missedStart;
  logic        resValid;
  logic [15:0] resData;
  logic [2:0]  resChan;
  logic        resSel;
  logic [3:0]  resLogical;

  always #5 clk = ~clk;

  adcseq_top u_dut (
    .clk(clk), .rstN(rstN), .goEn(goEn), .seqMode(seqMode), .lastChan(lastChan),
    .globalGain(globalGain), .gainTable(gainTable), .rateDiv(rateDiv), .adcSel(adcSel),
    .adcBusy(adcBusy), .adcDone(adcDone), .adcData(adcData), .convStart(convStart),
    .convChan(convChan), .convGain(convGain), .missedStart(missedStart),
    .resValid(resValid), .resData(resData), .resChan(resChan), .resSel(resSel),
    .resLogical(resLogical)
  );

  // ADC model: fixed busy window, then one done pulse carrying channel and gain
  int          adcLat = 5;
  int          busyCnt;
  logic [15:0] pend;

  always @(posedge clk) begin
    if (!rstN) begin
      adcBusy <= 1'b0;
      adcDone <= 1'b0;
      adcData <= '0;
      busyCnt <= 0;
      pend    <= '0;
    end else begin
      adcDone <= 1'b0;
      if (convStart) begin
        adcBusy <= 1'b1;
        busyCnt <= adcLat;
        pend    <= {4'hA, 3'b000, convGain, 3'b000, convChan};
      end else if (busyCnt > 1) begin
        busyCnt <= busyCnt - 1;
      end else if (busyCnt == 1) begin
        busyCnt <= 0;
        adcBusy <= 1'b0;
        adcDone <= 1'b1;
        adcData <= pend;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event logs
  int sChan [64];
  int sGain [64];
  int sCyc  [64];
  int rChan [64];
  int rData [64];
  int rSel  [64];
  int rLog  [64];
  int nStart, nRes, nMiss;

  always @(negedge clk) begin
    if (rstN) begin
      if (convStart && nStart < 64) begin
        sChan[nStart] = int'(convChan);
        sGain[nStart] = int'(convGain);
        sCyc[nStart]  = cyc;
        nStart++;
      end
      if (resValid && nRes < 64) begin
        rChan[nRes] = int'(resChan);
        rData[nRes] = int'(resData);
        rSel[nRes]  = int'(resSel);
        rLog[nRes]  = int'(resLogical);
        nRes++;
      end
      if (missedStart) nMiss++;
    end
  end

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearLogs();
    nStart = 0;
    nRes   = 0;
    nMiss  = 0;
  endtask

  task automatic waitStarts(input int n, input int limit);
    for (int i = 0; i < limit && nStart < n; i++) @(negedge clk);
  endtask

  task automatic stopAndDrain();
    @(negedge clk);
    goEn = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input int last, input int g, input int div, input bit sel);
    @(negedge clk);
    seqMode    = m;
    lastChan   = 3'(last);
    globalGain = 3'(g);
    rateDiv    = 16'(div);
    adcSel     = sel;
  endtask

  task automatic checkResults(input string tag, input bit sel);
    for (int i = 0; i < nRes; i++) begin
      chk(rChan[i] == (rData[i] & 7), {tag, " R10 resChan"}, rChan[i], rData[i] & 7);
      chk(rSel[i] == int'(sel), {tag, " R10 resSel"}, rSel[i], int'(sel));
      chk(rLog[i] == rChan[i] + (sel ? 8 : 0), {tag, " R10 resLogical"}, rLog[i], rChan[i] + (sel ? 8 : 0));
      chk(i < nStart && rChan[i] == sChan[i], {tag, " R10 result order"}, rChan[i], sChan[i]);
    end
  endtask

  task automatic t_reset();
    chk(convStart == 1'b0, "R8 reset convStart", int'(convStart), 0);
    chk(resValid == 1'b0, "R8 reset resValid", int'(resValid), 0);
    chk(missedStart == 1'b0, "R8 reset missedStart", int'(missedStart), 0);
  endtask

  task automatic t_single();
    adcLat = 5;
    setup(2'b00, 5, 3, 40, 1'b0);
    clearLogs();
    goEn = 1'b1;
    waitStarts(4, 400);
    stopAndDrain();
    chk(nStart == 4, "R8 no start after go low", nStart, 4);
    for (int i = 0; i < 4; i++) begin
      chk(sChan[i] == 5, "R3 single-input channel", sChan[i], 5);
      chk(sGain[i] == 3, "R3 single-input gain", sGain[i], 3);
    end
    for (int i = 1; i < 4; i++)
      chk(sCyc[i] - sCyc[i-1] == 40, "R1 period 40", sCyc[i] - sCyc[i-1], 40);
    chk(nRes == 4, "R10 result count", nRes, 4);
    checkResults("single", 1'b0);
  endtask

  task automatic t_basic();
    int expCh [5] = '{0, 1, 2, 0, 1};
    adcLat = 5;
    setup(2'b11, 2, 6, 30, 1'b1);
    clearLogs();
    goEn = 1'b1;
    waitStarts(2, 200);
    @(negedge clk);
    globalGain = 3'd1;   // ignored until restart
    lastChan   = 3'd7;
    waitStarts(5, 300);
    stopAndDrain();
    chk(nStart == 5, "R4 start count", nStart, 5);
    for (int i = 0; i < 5; i++) begin
      chk(sChan[i] == expCh[i], "R4 scan channel and wrap", sChan[i], expCh[i]);
      chk(sGain[i] == 6, "R7 gain held after change", sGain[i], 6);
    end
    for (int i = 1; i < 5; i++)
      chk(sCyc[i] - sCyc[i-1] == 30, "R1 period 30", sCyc[i] - sCyc[i-1], 30);
    chk(nMiss == 0, "R9 no missed start when idle", nMiss, 0);
    checkResults("basic", 1'b1);
    // restart after go low begins at input 0
    setup(2'b11, 2, 6, 30, 1'b1);
    clearLogs();
    goEn = 1'b1;
    waitStarts(1, 100);
    stopAndDrain();
    chk(nStart == 1 && sChan[0] == 0, "R8 restart at input 0", sChan[0], 0);
  endtask

  task automatic t_adv();
    int expCh [5] = '{0, 1, 2, 3, 0};
    adcLat = 5;
    for (int i = 0; i < 8; i++) gainTable[i*3 +: 3] = 3'(7 - i);
    setup(2'b10, 3, 2, 25, 1'b0);
    clearLogs();
    goEn = 1'b1;
    waitStarts(5, 300);
    stopAndDrain();
    chk(nStart == 5, "R5 start count", nStart, 5);
    for (int i = 0; i < 5; i++) begin
      chk(sChan[i] == expCh[i], "R5 advanced channel", sChan[i], expCh[i]);
      chk(sGain[i] == 7 - expCh[i], "R5 per-input gain", sGain[i], 7 - expCh[i]);
    end
    checkResults("adv", 1'b0);
  endtask

  task automatic t_update();
    int expCh [7] = '{0, 1, 2, 3, 4, 0, 1};
    int expG  [7] = '{1, 1, 1, 5, 5, 5, 5};
    adcLat = 5;
    setup(2'b11, 7, 1, 30, 1'b0);
    clearLogs();
    goEn = 1'b1;
    waitStarts(3, 200);
    @(negedge clk);
    seqMode    = 2'b01;
    lastChan   = 3'd4;
    globalGain = 3'd5;
    waitStarts(7, 400);
    stopAndDrain();
    chk(nStart == 7, "R6 start count", nStart, 7);
    for (int i = 0; i < 7; i++) begin
      chk(sChan[i] == expCh[i], "R6 pointer continues", sChan[i], expCh[i]);
      chk(sGain[i] == expG[i], "R6 new gain adopted", sGain[i], expG[i]);
    end
  endtask

  task automatic t_shot();
    adcLat = 5;
    setup(2'b11, 3, 4, 0, 1'b0);
    clearLogs();
    goEn = 1'b1;
    repeat (150) @(negedge clk);
    chk(nStart == 4, "R2 one scan", nStart, 4);
    for (int i = 0; i < 4 && i < nStart; i++)
      chk(sChan[i] == i, "R2 scan order", sChan[i], i);
    stopAndDrain();
    setup(2'b00, 6, 2, 0, 1'b0);
    clearLogs();
    goEn = 1'b1;
    repeat (100) @(negedge clk);
    chk(nStart == 1, "R2 one conversion", nStart, 1);
    chk(sChan[0] == 6, "R2 single channel", sChan[0], 6);
    stopAndDrain();
  endtask

  task automatic t_missed();
    adcLat = 10;
    setup(2'b11, 7, 0, 4, 1'b0);
    clearLogs();
    goEn = 1'b1;
    repeat (120) @(negedge clk);
    stopAndDrain();
    chk(nMiss > 0, "R9 missed start flagged", nMiss, 1);
    chk(nStart > 2, "R9 starts continue", nStart, 3);
    for (int i = 1; i < nStart; i++)
      chk(sCyc[i] - sCyc[i-1] > 10, "R9 no start while busy", sCyc[i] - sCyc[i-1], 11);
    chk(nRes == nStart, "R9 one result per start", nRes, nStart);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    goEn = 1'b0;
    seqMode = 2'b00;
    lastChan = '0;
    globalGain = '0;
    gainTable = '0;
    rateDiv = '0;
    adcSel = 1'b0;
    clearLogs();
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_basic();
    t_adv();
    t_update();
    t_shot();
    t_missed();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule